// File: doc/BRIEF.md
# Serial GPIO Interrupt and Register Bank

This block is the register and interrupt side of a serial GPIO controller. Up to four groups of 32 pins are shifted in and out elsewhere; here, each group's parallel input word arrives together with a one-cycle sample-valid strobe. The output word is held in a latch that drives the pins. A plain 32-bit read/write bus gives software access to these registers for each group:

- the sampled inputs;
- the output latch;
- an output readback;
- an interrupt enable;
- three trigger-mode words;
- a sticky, write-one-to-clear status word.

On every valid sample, each pin's new value is compared with its previous sample. The pin's trigger mode decides whether a status bit is set. All groups share one interrupt line, which is high while any status bit is set and enabled. Three per-pin bits select the trigger mode:

| Bit | Value 0 | Value 1 |
|-----|---------|---------|
| Polarity | falling edge or low level | rising edge or high level |
| Kind | edge | level |
| Both-edge (edge kind only) | single edge | both edges |

Software programs these bits and services the status word.

Top module: `sgpio_regbank`

## Requirements
- R1: After reset, every enable, trigger-mode, status and output-latch bit is 0. The interrupt line is low, and the pins are driven low.
- R2: Reading a group's value register (offset 0x00 from its base) returns the most recent valid sample. Writing that register loads the output latch, and the latch drives the pins from the next cycle. The output readback register returns the latch. Writing the value register does not change what it reads back. The pins change only on a bus write.
- R3: When the kind bit is 0 and the both-edge bit is 0, a status bit is set on a 1-to-0 change if polarity is 0. It is set on a 0-to-1 change if polarity is 1. Reset selects falling edge.
- R4: When the kind bit is 0 and the both-edge bit is 1, a status bit is set on any change of the pin, whatever its polarity bit.
- R5: When the kind bit is 1, a status bit is set on every valid sample in which the pin equals its polarity bit (1 = high level, 0 = low level). This holds even right after software has cleared the bit. It is not set when the pin differs from its polarity bit.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a clear and a new trigger hit the same bit in the same cycle, the bit ends up set.
- R7: Status bits change only on a valid sample or a status write. Sample data without the strobe has no effect. The first valid sample after reset only records the inputs and sets no status bit.
- R8: The interrupt line is the OR, over all groups and pins, of status AND enable. A status bit latches even while its enable is 0.
- R9: The register offsets from each group's base are value 0x00, enable 0x04, polarity 0x08, kind 0x0C, both-edge 0x10 and status 0x14. The group bases are 0x000, 0x01C, 0x038 and 0x090. The output readback registers are at 0x070, 0x074, 0x078 and 0x07C. Readback writes are ignored. Unmapped addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address for read and write |
| bus_wdata | input | PIN_W | Write data |
| bus_rdata | output | PIN_W | Read data for bus_addr, combinational |
| smp_valid | input | 1 | New parallel input sample present |
| smp_in | input | NBANKS*PIN_W | Sampled inputs, group 0 in the low word |
| pin_out | output | NBANKS*PIN_W | Output latches, group 0 in the low word |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong stored previous sample or trigger-mode bit shows up as a status word that is wrong on the bus read right after the next strobe. If the enable is set, the interrupt line shows it one cycle after that strobe. A corrupted output latch reaches the pins one cycle after the faulty write, and the readback register shows it. Because status is sticky, one spurious or missed hit persists until it is cleared. A per-clock model comparison of the interrupt and pins therefore catches the error within the cycle after the strobe.

// File: rtl/sgpio_pkg.sv
package sgpio_pkg;

    typedef enum logic [2:0] {
        FLD_NONE,
        FLD_VAL,
        FLD_RDBK,
        FLD_EN,
        FLD_POL,
        FLD_KIND,
        FLD_DUAL,
        FLD_ST
    } fld_e;

    localparam int MAP_BANKS = 4;
    localparam logic [15:0] RDBK_BASE = 16'h0070;

    typedef struct packed {
        logic       hit;
        logic [1:0] bank;
        fld_e       fld;
    } dec_t;

    function automatic logic [15:0] grp_base(input int b);
        case (b)
            0:       return 16'h0000;
            1:       return 16'h001C;
            2:       return 16'h0038;
            default: return 16'h0090;
        endcase
    endfunction

    function automatic dec_t decode(input logic [15:0] a);
        dec_t d;
        logic [15:0] gb;
        d = '{hit: 1'b0, bank: 2'd0, fld: FLD_NONE};
        for (int b = 0; b < MAP_BANKS; b++) begin
            gb = grp_base(b);
            if (a == gb) begin
                d = '{hit: 1'b1, bank: 2'(b), fld: FLD_VAL};
            end else if (a == gb + 16'h0004) begin
                d = '{hit: 1'b1, bank: 2'(b), fld: FLD_EN};
            end else if (a == gb + 16'h0008) begin
                d = '{hit: 1'b1, bank: 2'(b), fld: FLD_POL};
            end else if (a == gb + 16'h000C) begin
                d = '{hit: 1'b1, bank: 2'(b), fld: FLD_KIND};
            end else if (a == gb + 16'h0010) begin
                d = '{hit: 1'b1, bank: 2'(b), fld: FLD_DUAL};
            end else if (a == gb + 16'h0014) begin
                d = '{hit: 1'b1, bank: 2'(b), fld: FLD_ST};
            end else if (a == RDBK_BASE + 16'(4 * b)) begin
                d = '{hit: 1'b1, bank: 2'(b), fld: FLD_RDBK};
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/sgpio_trig.sv
module sgpio_trig #(
    parameter int W = 32
) (
    input  logic [W-1:0] prev,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] dual,
    output logic [W-1:0] fire
);
    logic [W-1:0] rise;
    logic [W-1:0] fall;
    logic [W-1:0] edge_hit;
    logic [W-1:0] level_hit;

    always_comb begin
        rise      = cur & ~prev;
        fall      = ~cur & prev;
        edge_hit  = (dual & (rise | fall))
                  | (~dual & pol & rise)
                  | (~dual & ~pol & fall);
        level_hit = (pol & cur) | (~pol & ~cur);
        fire      = (lvl & level_hit) | (~lvl & edge_hit);
    end
endmodule

// File: rtl/sgpio_bank.sv
module sgpio_bank
    import sgpio_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  fld_e         fld,
    input  logic [W-1:0] wdata,
    input  logic         smp_valid,
    input  logic         primed,
    input  logic [W-1:0] smp_in,
    output logic [W-1:0] rd_word,
    output logic [W-1:0] pins,
    output logic [W-1:0] st_o,
    output logic [W-1:0] en_o
);
    typedef struct packed {
        logic [W-1:0] inp;
        logic [W-1:0] outp;
        logic [W-1:0] en;
        logic [W-1:0] pol;
        logic [W-1:0] kind;
        logic [W-1:0] dual;
        logic [W-1:0] st;
    } bank_t;

    bank_t        s_d;
    bank_t        s_q;
    logic [W-1:0] fire;

    sgpio_trig #(.W(W)) u_trig (
        .prev (s_q.inp),
        .cur  (smp_in),
        .pol  (s_q.pol),
        .lvl  (s_q.kind),
        .dual (s_q.dual),
        .fire (fire)
    );

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            case (fld)
                FLD_VAL:  s_d.outp = wdata;
                FLD_EN:   s_d.en   = wdata;
                FLD_POL:  s_d.pol  = wdata;
                FLD_KIND: s_d.kind = wdata;
                FLD_DUAL: s_d.dual = wdata;
                FLD_ST:   s_d.st   = s_q.st & ~wdata;
                default:  s_d.st   = s_q.st;
            endcase
        end
        if (smp_valid) begin
            s_d.inp = smp_in;
            if (primed) begin
                s_d.st = s_d.st | fire;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (fld)
            FLD_VAL:  rd_word = s_q.inp;
            FLD_RDBK: rd_word = s_q.outp;
            FLD_EN:   rd_word = s_q.en;
            FLD_POL:  rd_word = s_q.pol;
            FLD_KIND: rd_word = s_q.kind;
            FLD_DUAL: rd_word = s_q.dual;
            FLD_ST:   rd_word = s_q.st;
            default:  rd_word = '0;
        endcase
    end

    assign pins = s_q.outp;
    assign st_o = s_q.st;
    assign en_o = s_q.en;
endmodule

// File: rtl/sgpio_regbank.sv
module sgpio_regbank
    import sgpio_pkg::*;
#(
    parameter int NBANKS = 4,
    parameter int PIN_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [PIN_W-1:0]        bus_wdata,
    output logic [PIN_W-1:0]        bus_rdata,
    input  logic                    smp_valid,
    input  logic [NBANKS*PIN_W-1:0] smp_in,
    output logic [NBANKS*PIN_W-1:0] pin_out,
    output logic                    irq
);
    localparam int ALL_W = NBANKS * PIN_W;

    logic             primed_d;
    logic             primed_q;
    dec_t             dec;
    logic [PIN_W-1:0] rd_w [NBANKS];
    logic [ALL_W-1:0] st_all;
    logic [ALL_W-1:0] en_all;

    assign dec = decode(16'(bus_addr));

    always_comb begin
        primed_d = primed_q | smp_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            primed_q <= 1'b0;
        end else begin
            primed_q <= primed_d;
        end
    end

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        logic sel;
        fld_e fld_b;

        assign sel   = dec.hit && (dec.bank == 2'(b));
        assign fld_b = sel ? dec.fld : FLD_NONE;

        sgpio_bank #(.W(PIN_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (bus_wr && sel),
            .fld       (fld_b),
            .wdata     (bus_wdata),
            .smp_valid (smp_valid),
            .primed    (primed_q),
            .smp_in    (smp_in[b*PIN_W +: PIN_W]),
            .rd_word   (rd_w[b]),
            .pins      (pin_out[b*PIN_W +: PIN_W]),
            .st_o      (st_all[b*PIN_W +: PIN_W]),
            .en_o      (en_all[b*PIN_W +: PIN_W])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NBANKS; b++) begin
            bus_rdata = bus_rdata | rd_w[b];
        end
    end

    assign irq = |(st_all & en_all);
endmodule

// File: rtl/sgpio_regbank_chk.sv
module sgpio_regbank_chk #(
    parameter int W = 128
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_wr,
    input logic         smp_valid,
    input logic         irq,
    input logic [W-1:0] pin_out,
    input logic [W-1:0] st_all,
    input logic [W-1:0] en_all
);
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (st_all == '0 && !irq));

    assert_pins_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(pin_out));

    assert_no_set_without_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ((st_all & ~$past(st_all)) == '0));

    assert_irq_rise_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(smp_valid) || $past(bus_wr)));

    assert_enable_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_all == '0) |-> !irq);
endmodule

bind sgpio_regbank sgpio_regbank_chk #(.W(NBANKS * PIN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .smp_valid (smp_valid),
    .irq       (irq),
    .pin_out   (pin_out),
    .st_all    (st_all),
    .en_all    (en_all)
);

// File: tb/sgpio_regbank_test.sv
`timescale 1ns/1ps
module sgpio_regbank_test;
    localparam int NB = 4;
    localparam int PW = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              bus_wr;
    logic [7:0]        bus_addr;
    logic [PW-1:0]     bus_wdata;
    logic [PW-1:0]     bus_rdata;
    logic              smp_valid;
    logic [NB*PW-1:0]  smp_in;
    logic [NB*PW-1:0]  pin_out;
    logic              irq;

    always #2 clk = ~clk;

    sgpio_regbank uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .smp_valid (smp_valid),
        .smp_in    (smp_in),
        .pin_out   (pin_out),
        .irq       (irq)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural reference state
    logic [31:0] m_in [NB];
    logic [31:0] m_out[NB];
    logic [31:0] m_en [NB];
    logic [31:0] m_pol[NB];
    logic [31:0] m_knd[NB];
    logic [31:0] m_dul[NB];
    logic [31:0] m_st [NB];
    logic [31:0] m_hit[NB];
    bit          m_primed;

    function automatic int base_of(input int b);
        case (b)
            0: return 'h00;
            1: return 'h1C;
            2: return 'h38;
            default: return 'h90;
        endcase
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NB; b++) begin
                m_in[b] = 0; m_out[b] = 0; m_en[b] = 0; m_pol[b] = 0;
                m_knd[b] = 0; m_dul[b] = 0; m_st[b] = 0; m_hit[b] = 0;
            end
            m_primed = 0;
        end else begin
            for (int b = 0; b < NB; b++) begin
                m_hit[b] = 0;
                for (int i = 0; i < 32; i++) begin
                    bit cur, old, f;
                    cur = smp_in[b*PW+i];
                    old = m_in[b][i];
                    if (m_knd[b][i])      f = (cur == m_pol[b][i]);
                    else if (m_dul[b][i]) f = (cur != old);
                    else if (m_pol[b][i]) f = cur && !old;
                    else                  f = !cur && old;
                    m_hit[b][i] = f && smp_valid && m_primed;
                end
                if (bus_wr) begin
                    int a;
                    a = int'(bus_addr);
                    if (a == base_of(b))           m_out[b] = bus_wdata;
                    else if (a == base_of(b) + 4)  m_en[b]  = bus_wdata;
                    else if (a == base_of(b) + 8)  m_pol[b] = bus_wdata;
                    else if (a == base_of(b) + 12) m_knd[b] = bus_wdata;
                    else if (a == base_of(b) + 16) m_dul[b] = bus_wdata;
                    else if (a == base_of(b) + 20) m_st[b]  = m_st[b] & ~bus_wdata;
                end
                if (smp_valid) m_in[b] = smp_in[b*PW +: PW];
                m_st[b] = m_st[b] | m_hit[b];
            end
            if (smp_valid) m_primed = 1;
        end
    end

    // per-clock comparison of interrupt and pins (R8, R2)
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            logic exp_irq;
            exp_irq = 0;
            for (int b = 0; b < NB; b++) exp_irq = exp_irq | (|(m_st[b] & m_en[b]));
            chk({31'd0, irq}, {31'd0, exp_irq}, "R8 irq vs model");
            for (int b = 0; b < NB; b++)
                chk(pin_out[b*PW +: PW], m_out[b], "R2 pins vs model");
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = 8'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd_x(input int a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = 8'(a);
        #1;
        chk(bus_rdata, exp, tag);
    endtask

    task automatic smp(input logic [31:0] d0, input logic [31:0] d1,
                       input logic [31:0] d2, input logic [31:0] d3);
        @(negedge clk);
        smp_valid = 1; smp_in = {d3, d2, d1, d0};
        @(negedge clk);
        smp_valid = 0;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        smp_valid = 0; smp_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd_x('h14, 0, "R1 status0");
        rd_x('h08, 0, "R1 pol0");
        rd_x('h7C, 0, "R1 readback3");
        rd_x('hA4, 0, "R1 status3");
        chk({31'd0, irq}, 0, "R1 irq");

        // modes: bank0 rising, bank1 default falling, bank2 mixed both-edge, bank3 level
        wr('h08, 32'hFFFF_FFFF);
        wr('h40, 32'hFF00_FF00);
        wr('h48, 32'h0000_FFFF);
        wr('h98, 32'h0000_FFFF);
        wr('h9C, 32'hFFFF_FFFF);

        // R7 first sample only primes
        smp(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0000_FFFF);
        rd_x('h14, 0, "R7 prime bank0");
        rd_x('hA4, 0, "R7 prime bank3 level");
        rd_x('h00, 32'hFFFF_FFFF, "R2 value read");
        rd_x('h1C, 32'hFFFF_FFFF, "R2 value read bank1");

        smp(32'h0000_FFFF, 32'h0F0F_0F0F, 32'h00FF_FF00, 32'h0000_FFFF);
        rd_x('h14, 0, "R3 rising no rise");
        rd_x('h30, 32'hF0F0_F0F0, "R3 falling default");
        rd_x('h4C, 32'h0000_FF00, "R4 both-edge rise");
        rd_x('hA4, 32'hFFFF_FFFF, "R5 level hit");

        wr('h4C, 32'hFFFF_FFFF);
        rd_x('h4C, 0, "R6 clear bank2");
        smp(32'hFFFF_0000, 32'h0F0F_0F0F, 32'hFF00_00F0, 32'h0000_FFFF);
        rd_x('h14, 32'hFFFF_0000, "R3 rising");
        rd_x('h4C, 32'hFFFF_FFF0, "R4 both-edge fall and mixed");
        rd_x('h30, 32'hF0F0_F0F0, "R3 no new fall");
        chk({31'd0, irq}, 0, "R8 latched with enable 0");

        wr('h04, 32'h0001_0000);
        chk({31'd0, irq}, 1, "R8 enable raises irq");
        wr('h14, 32'h0001_0000);
        rd_x('h14, 32'hFFFE_0000, "R6 w1c");
        chk({31'd0, irq}, 0, "R8 irq drops after clear");
        wr('h14, 32'h0);
        rd_x('h14, 32'hFFFE_0000, "R6 write zero keeps");

        // R7 data without strobe
        @(negedge clk);
        smp_in = '0;
        repeat (3) @(negedge clk);
        rd_x('h14, 32'hFFFE_0000, "R7 no strobe status");
        rd_x('h00, 32'hFFFF_0000, "R7 no strobe value");

        // R5 level re-set after clear
        wr('hA4, 32'hFFFF_FFFF);
        rd_x('hA4, 0, "R5 cleared");
        smp(32'hFFFF_0000, 32'h0F0F_0F0F, 32'hFF00_00F0, 32'h0000_FFFF);
        rd_x('hA4, 32'hFFFF_FFFF, "R5 re-set while held");
        wr('hA4, 32'hFFFF_FFFF);
        smp(32'hFFFF_0000, 32'h0F0F_0F0F, 32'hFF00_00F0, 32'hFFFF_0000);
        rd_x('hA4, 0, "R5 condition absent");

        // R6 set wins over same-cycle clear
        @(negedge clk);
        smp_valid = 1; smp_in = {32'h0000_FFFF, 32'hFF00_00F0, 32'h0F0F_0F0F, 32'hFFFF_0000};
        bus_wr = 1; bus_addr = 8'hA4; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        smp_valid = 0; bus_wr = 0;
        rd_x('hA4, 32'hFFFF_FFFF, "R6 set beats clear");

        // R2 outputs
        wr('h90, 32'hCAFE_1234);
        chk(pin_out[127:96], 32'hCAFE_1234, "R2 pins bank3");
        rd_x('h7C, 32'hCAFE_1234, "R2 readback bank3");
        rd_x('h90, 32'h0000_FFFF, "R2 value still input");
        wr('h1C, 32'h1234_5678);
        rd_x('h74, 32'h1234_5678, "R2 readback bank1");

        // R9 map and ignored accesses
        wr('h70, 32'hFFFF_FFFF);
        rd_x('h70, 0, "R9 readback write ignored");
        chk(pin_out[31:0], 0, "R9 pins bank0 untouched");
        wr('h60, 32'hFFFF_FFFF);
        rd_x('h60, 0, "R9 unmapped read");
        rd_x('hA8, 0, "R9 unmapped past map");
        rd_x('h98, 32'h0000_FFFF, "R9 polarity bank3 offset");
        rd_x('h44, 32'h0000_0000, "R9 kind bank2 offset");

        wr('h94, 32'h0000_0001);
        chk({31'd0, irq}, 1, "R8 bank3 enable");

        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule